// File: doc/BRIEF.md
# Transparent serial character transmitter

This block turns parallel words into a serial bit stream on one data line, with a bit clock beside it. Words arrive over a valid/ready handshake. Each word carries an end-of-frame marker. Within a frame, characters follow one another on the line with no idle gap. After the character marked as the end of frame, the line goes idle (logic 1) until the next word is accepted.

A 16-bit mode register sets the block up. It holds a transmit enable, a reverse-order bit and a 4-bit length code, and every bit of it reads back. Each bit on the line lasts `DIV` clock cycles. The bit clock is low for the first half of each bit period and high for the second half, so a receiver can sample on its rising edge.

If a frame is still open and no word is waiting when the current character ends, that is an underrun. The block stops the frame, raises a sticky underrun flag and gives an interrupt pulse if the interrupt is enabled. It then stays halted until a restart command arrives.

Top module: `ser_char_tx`

## Requirements
- R1: After reset, `mode_rdata` is 0, `ser_out` is 1, `tx_ready` is 0, `un_flag` is 0, `txe_irq` is 0 and `bit_clk` is 0.
- R2: A cycle with `mode_we` high stores `mode_wdata`, and all 16 bits read back on `mode_rdata` from the next cycle on. In this register, bit 1 is the transmit enable, bits 14:11 are the length code N, and bit 8 is the reverse-order bit.
- R3: For N from 3 to 15, a character is N+1 bits long. Each bit holds `ser_out` for `DIV` cycles. Bit 0 of the character starts in the cycle after the word is accepted.
- R4: Length codes 0, 1 and 2 produce 4-bit characters.
- R5: Word bits at or above the character length have no effect on `ser_out`.
- R6: With the reverse-order bit clear, the least significant bit of the character goes out first. With it set, the most significant bit (bit length-1) goes out first.
- R7: Inside a frame, `tx_ready` is high in the last cycle of the character's last bit. A word accepted there starts in the next cycle, with no idle gap.
- R8: An underrun happens when a character that is not end-of-frame ends with `tx_valid` low. From the next cycle on, `un_flag` is 1 and `ser_out` is 1. If `irq_en` is high, `txe_irq` is high for exactly one cycle.
- R9: With `irq_en` low, an underrun still sets `un_flag`, but `txe_irq` stays 0.
- R10: While halted, `tx_ready` stays 0 even when `tx_valid` is high. A one-cycle `restart` pulse clears `un_flag` and returns the block to idle, with `tx_ready` high from the next cycle on when the enable bit is set.
- R11: After an end-of-frame character, `un_flag` stays 0, `ser_out` is 1 and `tx_ready` is high when the enable bit is set.
- R12: With the enable bit clear, an idle block keeps `tx_ready` at 0 and `ser_out` at 1, so no frame starts.
- R13: `bit_clk` is 0 in the first half of each bit period and 1 in the second half. It is 0 while the block is idle or halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 16 | Mode register write data |
| mode_rdata | output | 16 | Mode register contents |
| irq_en | input | 1 | Underrun interrupt enable |
| restart | input | 1 | Restart command pulse; leaves the halt state |
| tx_valid | input | 1 | A word is offered |
| tx_data | input | 16 | Word to send |
| tx_last | input | 1 | The offered word ends the frame |
| tx_ready | output | 1 | The block takes the word in this cycle |
| ser_out | output | 1 | Serial data line, 1 when idle |
| bit_clk | output | 1 | Bit clock, high in the second half of each bit |
| un_flag | output | 1 | Sticky underrun status |
| txe_irq | output | 1 | One-cycle underrun interrupt pulse |

## Verification
A wrong bit counter or a wrong length decode shows up first as a wrong bit value in the very character it hits. It also moves the `tx_ready` cycle at the character boundary, and the bench checks that cycle directly. A flaw in the reverse or masking logic shows up in the bits on the line as soon as the first character is sent. A wrong control state shows up one cycle after a boundary as a wrong `un_flag`, `txe_irq` or `tx_ready`, or as a line that does not go back to 1.

// File: rtl/ser_char_tx_pkg.sv
package ser_char_tx_pkg;
  localparam int WORD_W = 16;
  localparam int LEN_W  = $clog2(WORD_W) + 1;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_HALT} tx_state_t;

  // Character length in bits from the length code; codes below 3 clamp to 4 bits.
  function automatic logic [LEN_W-1:0] char_len(input logic [CODE_W-1:0] code);
    if (code < 4'd3) return LEN_W'(4);
    return LEN_W'(code) + LEN_W'(1);
  endfunction

  // Mask the word to the character length and put it in shift-out order (bit 0 leaves first).
  function automatic logic [WORD_W-1:0] line_order(input logic [WORD_W-1:0] data,
                                                   input logic [LEN_W-1:0] len,
                                                   input logic rev);
    logic [WORD_W-1:0] res;
    res = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (i < int'(len)) begin
        res[i] = rev ? data[int'(len) - 1 - i] : data[i];
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/ser_char_tx_mode.sv
module ser_char_tx_mode
  import ser_char_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              enable,
  output logic              rev,
  output logic [CODE_W-1:0] len_code
);
  logic [WORD_W-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  mode_q <= '0;
    else if (we) mode_q <= wdata;
  end

  assign rdata    = mode_q;
  assign enable   = mode_q[1];
  assign rev      = mode_q[8];
  assign len_code = mode_q[14:11];

  assert_mode_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> rdata == $past(wdata));
endmodule

// File: rtl/ser_char_tx_shift.sv
module ser_char_tx_shift
  import ser_char_tx_pkg::*;
#(
  parameter int DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              active,
  output logic              ser_bit,
  output logic              bit_clk,
  output logic              char_end
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [WORD_W-1:0] shreg;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  bitcnt;
  logic [DIV_W-1:0]  divcnt;
  logic              bit_end;

  assign bit_end  = active && (divcnt == DIV_W'(DIV - 1));
  assign char_end = bit_end && (bitcnt == len_q - LEN_W'(1));
  assign ser_bit  = active ? shreg[0] : 1'b1;
  assign bit_clk  = active && (divcnt >= DIV_W'(DIV / 2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      len_q  <= LEN_W'(4);
      bitcnt <= '0;
      divcnt <= '0;
    end else if (load) begin
      shreg  <= load_word;
      len_q  <= load_len;
      bitcnt <= '0;
      divcnt <= '0;
    end else if (active) begin
      divcnt <= bit_end ? '0 : divcnt + DIV_W'(1);
      if (bit_end) begin
        shreg  <= {1'b0, shreg[WORD_W-1:1]};
        bitcnt <= bitcnt + LEN_W'(1);
      end
    end
  end

  assert_bitcnt_in_char_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> bitcnt < len_q);
endmodule

// File: rtl/ser_char_tx_ctrl.sv
module ser_char_tx_ctrl
  import ser_char_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic irq_en,
  input  logic restart,
  input  logic tx_valid,
  input  logic tx_last,
  input  logic char_end,
  output logic tx_ready,
  output logic load,
  output logic active,
  output logic un_flag,
  output logic txe_irq
);
  tx_state_t state;
  logic      last_q;
  logic      underrun;

  assign active   = (state == ST_SHIFT);
  assign tx_ready = (state == ST_IDLE && enable) || (active && char_end && !last_q);
  assign load     = tx_valid && tx_ready;
  assign underrun = active && char_end && !last_q && !tx_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      last_q  <= 1'b0;
      un_flag <= 1'b0;
      txe_irq <= 1'b0;
    end else begin
      txe_irq <= 1'b0;
      if (load) last_q <= tx_last;
      unique case (state)
        ST_IDLE:  if (load) state <= ST_SHIFT;
        ST_SHIFT: begin
          if (char_end && last_q) state <= ST_IDLE;
          else if (underrun) begin
            state   <= ST_HALT;
            un_flag <= 1'b1;
            txe_irq <= irq_en;
          end
        end
        ST_HALT: if (restart) begin
          state   <= ST_IDLE;
          un_flag <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_underrun_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && char_end && !last_q && !tx_valid) |=> (state == ST_HALT) && un_flag);
  assert_irq_with_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    txe_irq |-> $rose(un_flag));
  assert_halt_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT && !restart) |=> (state == ST_HALT) && !tx_ready);
  assert_no_underrun_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && char_end && last_q) |=> (state == ST_IDLE) && !un_flag);
endmodule

// File: rtl/ser_char_tx.sv
module ser_char_tx
  import ser_char_tx_pkg::*;
#(
  parameter int DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_we,
  input  logic [15:0] mode_wdata,
  output logic [15:0] mode_rdata,
  input  logic        irq_en,
  input  logic        restart,
  input  logic        tx_valid,
  input  logic [15:0] tx_data,
  input  logic        tx_last,
  output logic        tx_ready,
  output logic        ser_out,
  output logic        bit_clk,
  output logic        un_flag,
  output logic        txe_irq
);
  logic              enable, rev, load, active, char_end;
  logic [CODE_W-1:0] len_code;
  logic [LEN_W-1:0]  len_now;
  logic [WORD_W-1:0] word_now;

  assign len_now  = char_len(len_code);
  assign word_now = line_order(tx_data, len_now, rev);

  ser_char_tx_mode u_mode (
    .clk(clk), .rst_n(rst_n), .we(mode_we), .wdata(mode_wdata),
    .rdata(mode_rdata), .enable(enable), .rev(rev), .len_code(len_code)
  );

  ser_char_tx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .irq_en(irq_en),
    .restart(restart), .tx_valid(tx_valid), .tx_last(tx_last),
    .char_end(char_end), .tx_ready(tx_ready), .load(load), .active(active),
    .un_flag(un_flag), .txe_irq(txe_irq)
  );

  ser_char_tx_shift #(.DIV(DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_word(word_now),
    .load_len(len_now), .active(active), .ser_bit(ser_out),
    .bit_clk(bit_clk), .char_end(char_end)
  );

  assert_bitclk_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!active) |-> !bit_clk && ser_out);
endmodule

// File: tb/tb_ser_char_tx.sv
module tb_ser_char_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [15:0] mode_wdata = '0;
  logic [15:0] mode_rdata;
  logic        irq_en = 1'b0;
  logic        restart = 1'b0;
  logic        tx_valid = 1'b0;
  logic [15:0] tx_data = '0;
  logic        tx_last = 1'b0;
  logic        tx_ready, ser_out, bit_clk, un_flag, txe_irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ser_char_tx #(.DIV(2)) dut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .mode_rdata(mode_rdata), .irq_en(irq_en), .restart(restart),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .ser_out(ser_out), .bit_clk(bit_clk),
    .un_flag(un_flag), .txe_irq(txe_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int bench_len(input int code);
    return (code < 3) ? 4 : code + 1;
  endfunction

  function automatic logic [15:0] expect_seq(input logic [15:0] d, input int len, input bit rev);
    logic [15:0] e = '0;
    for (int k = 0; k < len; k++) e[k] = rev ? d[len - 1 - k] : d[k];
    return e;
  endfunction

  task automatic write_mode(input logic [15:0] v);
    @(negedge clk); mode_we = 1'b1; mode_wdata = v;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic config_tx(input int code, input bit rev);
    write_mode(16'((code & 15) << 11) | 16'(rev << 8) | 16'h0002);
  endtask

  // Two-character frame: d0 then d1 (end of frame). Checks bits, bit clock and boundary ready.
  task automatic send_frame(input logic [15:0] d0, input logic [15:0] d1, input int code, input bit rev);
    int len = bench_len(code);
    logic [15:0] got;
    @(negedge clk); tx_data = d0; tx_last = 1'b0; tx_valid = 1'b1;
    #1 chk(tx_ready === 1'b1, "R11 idle ready", 32'(tx_ready), 1);
    for (int c = 0; c < 2; c++) begin
      got = '0;
      for (int k = 0; k < len; k++) begin
        @(negedge clk);
        if (k == 0) begin
          if (c == 0) begin tx_data = d1; tx_last = 1'b1; end
          else tx_valid = 1'b0;
        end
        got[k] = ser_out;
        if (k == 0) chk(bit_clk === 1'b0, "R13 low half", 32'(bit_clk), 0);
        @(negedge clk);
        chk(ser_out === got[k], "R3 bit held DIV cycles", 32'(ser_out), 32'(got[k]));
        if (k == 0) chk(bit_clk === 1'b1, "R13 high half", 32'(bit_clk), 1);
        if (k == len - 1)
          chk(tx_ready === (c == 0), "R7 boundary ready", 32'(tx_ready), 32'(c == 0));
      end
      chk(got === expect_seq(c ? d1 : d0, len, rev), "R3 R4 R5 R6 character bits",
          32'(got), 32'(expect_seq(c ? d1 : d0, len, rev)));
    end
    @(negedge clk);
    chk(ser_out === 1'b1 && un_flag === 1'b0 && tx_ready === 1'b1, "R11 end of frame idle",
        {29'd0, ser_out, un_flag, tx_ready}, 32'b101);
  endtask

  task automatic underrun_case(input int code, input bit ie);
    int len = bench_len(code);
    irq_en = ie;
    @(negedge clk); tx_data = 16'h1234; tx_last = 1'b0; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
    for (int n = 1; n < 2 * len; n++) @(negedge clk);
    chk(tx_ready === 1'b1, "R7 ready at boundary before underrun", 32'(tx_ready), 1);
    @(negedge clk);
    chk(un_flag === 1'b1 && ser_out === 1'b1, "R8 underrun flag and idle line",
        {30'd0, un_flag, ser_out}, 32'b11);
    if (ie) chk(txe_irq === 1'b1, "R8 interrupt pulse", 32'(txe_irq), 1);
    else chk(txe_irq === 1'b0, "R9 interrupt masked", 32'(txe_irq), 0);
    tx_valid = 1'b1;
    @(negedge clk);
    chk(txe_irq === 1'b0, "R8 pulse one cycle", 32'(txe_irq), 0);
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      chk(tx_ready === 1'b0 && un_flag === 1'b1 && ser_out === 1'b1, "R10 halted",
          {29'd0, tx_ready, un_flag, ser_out}, 32'b011);
    end
    tx_valid = 1'b0; restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    chk(un_flag === 1'b0 && tx_ready === 1'b1, "R10 restart clears",
        {30'd0, un_flag, tx_ready}, 32'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mode_rdata === 16'h0 && ser_out === 1'b1 && tx_ready === 1'b0 && un_flag === 1'b0 &&
        txe_irq === 1'b0 && bit_clk === 1'b0, "R1 reset state",
        {mode_rdata, 10'd0, ser_out, tx_ready, un_flag, txe_irq, bit_clk, 1'b0}, 32'h0000_0020);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mode_rdata === 16'h0 && tx_ready === 1'b0, "R1 after reset", 32'(mode_rdata), 0);

    foreach (pat_mode[i]) begin
      write_mode(pat_mode[i]);
      chk(mode_rdata === pat_mode[i], "R2 mode readback", 32'(mode_rdata), 32'(pat_mode[i]));
    end

    write_mode(16'h0000);
    tx_valid = 1'b1; tx_data = 16'hFFFF;
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      chk(tx_ready === 1'b0 && ser_out === 1'b1, "R12 disabled no start",
          {30'd0, tx_ready, ser_out}, 32'b01);
    end
    tx_valid = 1'b0;

    for (int code = 0; code < 16; code++) begin
      for (int r = 0; r < 2; r++) begin
        config_tx(code, r[0]);
        send_frame(16'hA5C3, 16'h5A3C, code, r[0]);
        send_frame(16'hFFF0, 16'h0001, code, r[0]);
        send_frame(16'h8000 | 16'(code * 16'h0913), 16'h7FFE ^ 16'(code), code, r[0]);
      end
    end

    config_tx(7, 1'b0);
    underrun_case(7, 1'b1);
    underrun_case(7, 1'b0);
    config_tx(1, 1'b1);
    underrun_case(1, 1'b1);
    config_tx(15, 1'b0);
    underrun_case(15, 1'b0);
    send_frame(16'hBEEF, 16'hC0DE, 15, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [15:0] pat_mode [4] = '{16'hFFFF, 16'h5AA5, 16'h8001, 16'h0000};
endmodule